// File: doc/BRIEF.md
# Decimal Six-to-Two Carry-Save Compressor (4221 Code)

This block takes six decimal operands of DIGITS digits and returns two decimal operands whose values add up to the same total. No carry ripples across the digit columns. Every digit uses the redundant 4221 code. Its four bits carry the weights 4, 2, 2 and 1, so all sixteen bit patterns are legal and stand for values 0 to 9. The block is meant to sit between a partial-product generator and a final carry-propagate decimal adder. The carry-propagate addition itself is not part of this block.

The reduction uses three levels of decimal 3:2 compressors. Each compressor applies one binary full adder to each bit position of three digits. The result is a sum digit and a carry digit of twice the weight. Before a carry vector enters the next level, a doubler multiplies it by two. The doubler recodes each digit into the 5211 code and shifts it left by one bit. The bit shifted out becomes a weight-1 transfer into the next digit up. Each of the four doublers can push one transfer out of the top column. These four transfers are output separately, each with weight 10^DIGITS. A parameter selects whether the outputs are registered.

Top module: `dec62_compress`

## Requirements
- R1: Digit i of every operand occupies bits [4i+3:4i], with bit weights 4, 2, 2, 1 from the top bit down. The value of sumOut plus the value of carOut plus 10^DIGITS times the number of set bits of topXfer equals the sum of the values of the six operands in opIn.
- R2: Bit 0 of the least significant digit of carOut is always 0.
- R3: In every digit of carOut, bits [3:1] take only the patterns 000, 001, 100, 101 or 111.
- R4: When all six operands are zero, sumOut, carOut and topXfer are all zero.
- R5: With OUT_REG=1, the outputs change only at a rising clock edge, where they take the result for the operands present at that edge. With OUT_REG=0, the outputs follow the operands combinationally.
- R6: While rstN is low, the registered sumOut, carOut and topXfer are held at zero, whatever the operands are.
- R7: When every digit of every operand is 1111, sumOut has 1110 in digit 0 and 1111 in all other digits. carOut has 1010 in digit 0 and 1111 in all other digits. All four bits of topXfer are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opIn | input | 6 x 4*DIGITS | Six 4221-coded decimal operands |
| sumOut | output | 4*DIGITS | Sum operand, 4221 code |
| carOut | output | 4*DIGITS | Doubled carry operand, 4221 code |
| topXfer | output | 4 | Transfers out of the top column, one from each doubler, each worth 10^DIGITS |

## Verification
A wrong doubler recoding or a wrong full-adder bit shows up in the same result as a total that no longer matches the operand sum. It may also show as an illegal carOut pattern. A transfer dropped at the top column shows up the same way, as a total that misses a multiple of 10^DIGITS. A register or reset fault shows up one edge later, as a result that belongs to the wrong operand set, or as nonzero outputs during reset. The all-ones operands give exact expected bit patterns that expose code-choice errors the value sum alone could hide.

// File: rtl/dec4221_pkg.sv
package dec4221_pkg;

  // Decimal value of a 4221-coded digit (weights 4,2,2,1).
  function automatic int digitVal(input logic [3:0] d);
    return 4 * int'(d[3]) + 2 * int'(d[2]) + 2 * int'(d[1]) + int'(d[0]);
  endfunction

  // Code a value 0..9 in 5211 (bit3 weight 5, then 2,1,1).
  // Bits [2:0] are chosen so that, after a left shift, they stay a valid 4221 pattern.
  function automatic logic [3:0] code5211(input int v);
    logic [3:0] c;
    int r;
    c[3] = (v >= 5);
    r = (v >= 5) ? v - 5 : v;
    case (r)
      0: c[2:0] = 3'b000;
      1: c[2:0] = 3'b001;
      2: c[2:0] = 3'b100;
      3: c[2:0] = 3'b101;
      default: c[2:0] = 3'b111;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dec_csa32.sv
module dec_csa32 #(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] inA,
  input  logic [4*DIGITS-1:0] inB,
  input  logic [4*DIGITS-1:0] inC,
  output logic [4*DIGITS-1:0] sumV,
  output logic [4*DIGITS-1:0] carV
);
  import dec4221_pkg::*;

  // One full adder for every bit; the carry keeps the bit's weight, doubled by the value.
  assign sumV = inA ^ inB ^ inC;
  assign carV = (inA & inB) | (inA & inC) | (inB & inC);

  for (genvar i = 0; i < DIGITS; i++) begin : g_chk
    always_comb begin
      if (!$isunknown({inA[4*i+:4], inB[4*i+:4], inC[4*i+:4]})) begin
        // R1
        csa_value_chk: assert (digitVal(inA[4*i+:4]) + digitVal(inB[4*i+:4]) + digitVal(inC[4*i+:4])
                               == digitVal(sumV[4*i+:4]) + 2 * digitVal(carV[4*i+:4]));
      end
    end
  end

endmodule

// File: rtl/dec_double.sv
module dec_double #(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] inV,
  output logic [4*DIGITS-1:0] outV,
  output logic                xferOut
);
  import dec4221_pkg::*;

  logic [DIGITS:0] xc;
  assign xc[0] = 1'b0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] code;
    assign code = code5211(digitVal(inV[4*i+:4]));
    // Left shift: top 5211 bit leaves as a ten; incoming transfer fills weight 1.
    assign outV[4*i+:4] = {code[2:0], xc[i]};
    assign xc[i+1] = code[3];

    always_comb begin
      if (!$isunknown({inV[4*i+:4], xc[i]})) begin
        // R1
        dbl_value_chk: assert (2 * digitVal(inV[4*i+:4]) + int'(xc[i])
                               == 10 * int'(xc[i+1]) + digitVal(outV[4*i+:4]));
        // R3
        dbl_code_chk: assert (outV[4*i+1+:3] != 3'b010 && outV[4*i+1+:3] != 3'b011
                              && outV[4*i+1+:3] != 3'b110);
      end
    end
  end

  assign xferOut = xc[DIGITS];

endmodule

// File: rtl/dec62_tree.sv
module dec62_tree #(
  parameter int DIGITS = 8
) (
  input  logic [5:0][4*DIGITS-1:0] opIn,
  output logic [4*DIGITS-1:0]      sumV,
  output logic [4*DIGITS-1:0]      carV,
  output logic [3:0]               xferV
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0] s1, h1, s2, h2, d1, d2;
  logic [W-1:0] s3, h3, d3, h4;

  // Level 1: two compressors side by side.
  dec_csa32 #(.DIGITS(DIGITS)) u_c1 (.inA(opIn[0]), .inB(opIn[1]), .inC(opIn[2]), .sumV(s1), .carV(h1));
  dec_csa32 #(.DIGITS(DIGITS)) u_c2 (.inA(opIn[3]), .inB(opIn[4]), .inC(opIn[5]), .sumV(s2), .carV(h2));
  dec_double #(.DIGITS(DIGITS)) u_d1 (.inV(h1), .outV(d1), .xferOut(xferV[0]));
  dec_double #(.DIGITS(DIGITS)) u_d2 (.inV(h2), .outV(d2), .xferOut(xferV[1]));

  // Level 2: d2 bypasses this level, so its doubler delay lines up with this compressor.
  dec_csa32 #(.DIGITS(DIGITS)) u_c3 (.inA(s1), .inB(s2), .inC(d1), .sumV(s3), .carV(h3));
  dec_double #(.DIGITS(DIGITS)) u_d3 (.inV(h3), .outV(d3), .xferOut(xferV[2]));

  // Level 3: final compressor, then its carry is doubled.
  dec_csa32 #(.DIGITS(DIGITS)) u_c4 (.inA(s3), .inB(d2), .inC(d3), .sumV(sumV), .carV(h4));
  dec_double #(.DIGITS(DIGITS)) u_d4 (.inV(h4), .outV(carV), .xferOut(xferV[3]));

endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage #(
  parameter int DIGITS  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4*DIGITS-1:0] dSum,
  input  logic [4*DIGITS-1:0] dCar,
  input  logic [3:0]          dXfer,
  output logic [4*DIGITS-1:0] qSum,
  output logic [4*DIGITS-1:0] qCar,
  output logic [3:0]          qXfer
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        qSum  <= '0;
        qCar  <= '0;
        qXfer <= '0;
      end else begin
        qSum  <= dSum;
        qCar  <= dCar;
        qXfer <= dXfer;
      end
    end

    // R5
    out_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (qSum == $past(dSum) && qCar == $past(dCar) && qXfer == $past(dXfer)));
  end else begin : g_comb
    assign qSum  = dSum;
    assign qCar  = dCar;
    assign qXfer = dXfer;
  end

endmodule

// File: rtl/dec62_compress.sv
module dec62_compress #(
  parameter int DIGITS  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [5:0][4*DIGITS-1:0] opIn,
  output logic [4*DIGITS-1:0]      sumOut,
  output logic [4*DIGITS-1:0]      carOut,
  output logic [3:0]               topXfer
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0] treeSum, treeCar;
  logic [3:0]   treeXfer;

  dec62_tree #(.DIGITS(DIGITS)) u_tree (
    .opIn(opIn), .sumV(treeSum), .carV(treeCar), .xferV(treeXfer)
  );

  dec_out_stage #(.DIGITS(DIGITS), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rstN(rstN),
    .dSum(treeSum), .dCar(treeCar), .dXfer(treeXfer),
    .qSum(sumOut), .qCar(carOut), .qXfer(topXfer)
  );

endmodule

// File: tb/sim_dec62_compress.sv
`timescale 1ns/1ps
module sim_dec62_compress;
  localparam int DIGITS = 8;
  localparam int W = 4 * DIGITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0][W-1:0] opIn = '0;
  logic [W-1:0] sumOut, carOut;
  logic [3:0] topXfer;

  always #10 clk = ~clk;

  dec62_compress #(.DIGITS(DIGITS), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .opIn(opIn),
    .sumOut(sumOut), .carOut(carOut), .topXfer(topXfer)
  );

  typedef struct { longint total; int kind; } exp_t;
  exp_t expQ[$];
  int nChk = 0;
  int nBad = 0;

  function automatic longint valOf(input logic [W-1:0] v);
    longint acc = 0;
    longint wt = 1;
    for (int i = 0; i < DIGITS; i++) begin
      acc += wt * longint'(4 * v[4*i+3] + 2 * v[4*i+2] + 2 * v[4*i+1] + v[4*i]);
      wt *= 10;
    end
    return acc;
  endfunction

  function automatic longint pow10(input int n);
    longint p = 1;
    for (int i = 0; i < n; i++) p *= 10;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(input logic [5:0][W-1:0] ops, input int kind);
    exp_t e;
    @(negedge clk);
    opIn = ops;
    e.total = 0;
    for (int k = 0; k < 6; k++) e.total += valOf(ops[k]);
    e.kind = kind;
    expQ.push_back(e);
  endtask

  // Scoreboard monitor: one result per rising edge after each pushed operand set.
  always @(posedge clk) begin
    #1;
    if (rstN && expQ.size() > 0) begin
      exp_t e;
      longint got;
      int badPat;
      e = expQ.pop_front();
      got = valOf(sumOut) + valOf(carOut) + pow10(DIGITS) * longint'($countones(topXfer));
      check(got == e.total, "R1 value", got, e.total);
      check(carOut[0] == 1'b0, "R2 carry lsb", longint'(carOut[0]), 0);
      badPat = 0;
      for (int i = 0; i < DIGITS; i++)
        if (carOut[4*i+1+:3] == 3'b010 || carOut[4*i+1+:3] == 3'b011 || carOut[4*i+1+:3] == 3'b110)
          badPat++;
      check(badPat == 0, "R3 carry pattern", badPat, 0);
      if (e.kind == 1) begin
        check(sumOut == '0 && carOut == '0 && topXfer == '0, "R4 zero in",
              valOf(sumOut) + valOf(carOut) + longint'(topXfer), 0);
      end
      if (e.kind == 2) begin
        logic [W-1:0] expS, expH;
        expS = '1; expS[3:0] = 4'b1110;
        expH = '1; expH[3:0] = 4'b1010;
        check(sumOut == expS, "R7 sum pattern", longint'(sumOut), longint'(expS));
        check(carOut == expH, "R7 carry pattern", longint'(carOut), longint'(expH));
        check(topXfer == 4'hF, "R7 transfers", longint'(topXfer), 15);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [5:0][W-1:0] ops;
    // R6: operands present, reset held low
    opIn = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sumOut == '0 && carOut == '0 && topXfer == '0, "R6 reset",
          valOf(sumOut) + valOf(carOut) + longint'(topXfer), 0);
    opIn = '0;
    rstN = 1'b1;

    // R4: zero operands
    drive('0, 1);
    drive('0, 1);
    // R5: new operands must not reach the outputs before the edge
    drive('1, 2);
    #1;
    check(sumOut == '0, "R5 held before edge", valOf(sumOut), 0);

    // R1: single operand active, others zero
    for (int k = 0; k < 6; k++) begin
      ops = '0;
      ops[k] = '1;
      drive(ops, 0);
    end

    // R1: random encodings, redundant ones included
    for (int n = 0; n < 500; n++) begin
      for (int k = 0; k < 6; k++)
        for (int i = 0; i < DIGITS; i++)
          ops[k][4*i+:4] = 4'($urandom_range(15));
      drive(ops, 0);
    end

    // R7 once more after random traffic
    drive('1, 2);
    drive('0, 1);

    @(negedge clk);
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule